// File: doc/BRIEF.md
# Ping-Pong Frequency Meter

This block measures an unknown, asynchronous input frequency against a fast reference clock. Two identical counter banks take turns. The active bank counts rising edges of the input and cycles of the reference clock for a fixed window of reference cycles, which is set by a parameter (default 100000, i.e. 1 ms at 100 MHz). The other bank holds the pair of counts from the previous window.

At the end of each window the banks swap roles on the same clock edge. The outgoing bank freezes with its final values, and the incoming bank is cleared and starts counting on the next cycle. Every reference cycle is therefore counted exactly once, and measurement never pauses.

After each swap, a registered read port presents the frozen pair together with the number of the bank it came from. At the same edge a level interrupt flag is raised. A processor reads the pair, derives the frequency ratio itself, and acknowledges the flag. If a new result arrives before the acknowledge, an overrun flag records that a result was lost.

Top module: `freq_pingpong_meter`

## Requirements
- R1: While reset is high and after its release until the first result, `irq_o`, `overrun_o`, `rd_evt_o`, `rd_ref_o` and `rd_bank_o` are all 0.
- R2: Every presented reference count equals the parameter `WINDOW` exactly.
- R3: For a periodic input of period T, the presented event count over a window of duration D (WINDOW reference periods) is floor(D/T) or floor(D/T)+1.
- R4: The bank number on `rd_bank_o` of the first result after reset is 1, and it alternates 1, 0, 1, ... with each later result.
- R5: `irq_o` goes high at the same clock edge at which the read port takes a new result, and stays high until a cycle with `ack_i` high and no new result. It is then low after that edge.
- R6: If a new result arrives while `irq_o` is high and `ack_i` is low, `overrun_o` is high after that edge. It stays high until `ack_i` is high, and the edge after that acknowledge clears it.
- R7: Between two results, the read port (`rd_evt_o`, `rd_ref_o`, `rd_bank_o`) holds its values unchanged.
- R8: Results appear at a steady interval of exactly `WINDOW` reference cycles.
- R9: An input that stays at a constant low level yields an event count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| meas_in | input | 1 | Asynchronous signal whose frequency is measured |
| ack_i | input | 1 | Processor acknowledge; clears the interrupt and overrun flags |
| irq_o | output | 1 | Level flag: a new result is on the read port |
| overrun_o | output | 1 | A result arrived while the previous one was unacknowledged |
| rd_evt_o | output | CNT_W | Input rising edges counted in the held window |
| rd_ref_o | output | CNT_W | Reference cycles counted in the held window |
| rd_bank_o | output | 1 | Number of the bank the held pair came from |

## Verification
The bank swap happens at the edge that closes a window. The read port and `irq_o` change one edge later, together. An acknowledge clears the flags at the very next edge. An input rising edge reaches the event counter three edges after it is sampled, and this constant shift does not change the count per window.

The bench runs a small window of 64 cycles. It samples every output at the falling clock edge: the first falling edge after a result appears, a later one to confirm the result is held, and the one after an acknowledge. Expected edge counts are computed from the driven period and the window duration in nanoseconds. The result interval is checked against a free-running cycle count.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int unsigned NUM_BANKS = 2;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;
endpackage

// File: rtl/fpm_sync_edge.sv
// Multi-stage synchronizer followed by a rising-edge detector.
module fpm_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fpm_counter.sv
// Up counter: reset or active-low clear zero it; enable advances it by one.
module fpm_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || !clr_n) q <= '0;
    else if (en)       q <= q + 1'b1;
  end
endmodule

// File: rtl/fpm_bank.sv
// One bank: an input-edge counter and a reference-cycle counter.
module fpm_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         run,
  input  logic         evt_pulse,
  output logic [W-1:0] evt_q,
  output logic [W-1:0] ref_q
);
  fpm_counter #(.W(W)) u_evt (
    .clk(clk), .rst(rst), .clr_n(clr_n), .en(run & evt_pulse), .q(evt_q)
  );
  fpm_counter #(.W(W)) u_ref (
    .clk(clk), .rst(rst), .clr_n(clr_n), .en(run), .q(ref_q)
  );
endmodule

// File: rtl/freq_pingpong_meter.sv
module freq_pingpong_meter #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned WINDOW      = 100000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             meas_in,
  input  logic             ack_i,
  output logic             irq_o,
  output logic             overrun_o,
  output logic [CNT_W-1:0] rd_evt_o,
  output logic [CNT_W-1:0] rd_ref_o,
  output logic             rd_bank_o
);
  import fpm_pkg::*;

  localparam int unsigned WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);

  logic             evt_pulse;
  logic [WIN_W-1:0] win_q;
  logic             win_end;
  bank_e            active_q;
  bank_e            held;
  logic             res_load_q;
  logic [CNT_W-1:0] evt_q [NUM_BANKS];
  logic [CNT_W-1:0] ref_q [NUM_BANKS];

  fpm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(meas_in), .rise_o(evt_pulse)
  );

  assign win_end = (win_q == WIN_LAST);
  assign held    = bank_e'(~active_q);

  // Window timer and role control; bank B counts first after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      win_q      <= '0;
      active_q   <= BANK_B;
      res_load_q <= 1'b0;
    end else begin
      res_load_q <= win_end;
      if (win_end) begin
        win_q    <= '0;
        active_q <= bank_e'(~active_q);
      end else begin
        win_q <= win_q + 1'b1;
      end
    end
  end

  // Outgoing bank takes its last count on the swap edge; incoming bank is zeroed.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic is_active;
    assign is_active = (active_q == bank_e'(b));
    fpm_bank #(.W(CNT_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .clr_n    (~(win_end & ~is_active)),
      .run      (is_active),
      .evt_pulse(evt_pulse),
      .evt_q    (evt_q[b]),
      .ref_q    (ref_q[b])
    );
  end

  // Read port and flags, all updated one edge after the swap.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_evt_o  <= '0;
      rd_ref_o  <= '0;
      rd_bank_o <= 1'b0;
      irq_o     <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (res_load_q) begin
        rd_evt_o  <= evt_q[held];
        rd_ref_o  <= ref_q[held];
        rd_bank_o <= held;
      end
      if (res_load_q)  irq_o <= 1'b1;
      else if (ack_i)  irq_o <= 1'b0;
      if (res_load_q && irq_o && !ack_i) overrun_o <= 1'b1;
      else if (ack_i)                    overrun_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned WINDOW = 100000
) (
  input logic             clk,
  input logic             rst,
  input logic             ack_i,
  input logic             new_res,
  input logic             irq_o,
  input logic             overrun_o,
  input logic [CNT_W-1:0] rd_evt_o,
  input logic [CNT_W-1:0] rd_ref_o,
  input logic             rd_bank_o
);
  p_ref_window_r2: assert property (@(posedge clk) disable iff (rst)
    new_res |=> (rd_ref_o == CNT_W'(WINDOW)));

  p_bank_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    new_res |=> (rd_bank_o != $past(rd_bank_o)));

  p_irq_set_r5: assert property (@(posedge clk) disable iff (rst)
    new_res |=> irq_o);

  p_irq_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !new_res) |=> !irq_o);

  p_overrun_set_r6: assert property (@(posedge clk) disable iff (rst)
    (new_res && irq_o && !ack_i) |=> overrun_o);

  p_overrun_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !ack_i) |=> overrun_o);

  p_held_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !new_res |=> ($stable(rd_evt_o) && $stable(rd_ref_o) && $stable(rd_bank_o)));
endmodule

bind freq_pingpong_meter fpm_checker #(.CNT_W(CNT_W), .WINDOW(WINDOW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ack_i    (ack_i),
  .new_res  (res_load_q),
  .irq_o    (irq_o),
  .overrun_o(overrun_o),
  .rd_evt_o (rd_evt_o),
  .rd_ref_o (rd_ref_o),
  .rd_bank_o(rd_bank_o)
);

// File: tb/freq_pingpong_meter_tb_top.sv
`timescale 1ns/1ps
module freq_pingpong_meter_tb_top;
  localparam int CNT_W  = 32;
  localparam int W      = 64;
  localparam int CLK_NS = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             meas_in = 1'b0;
  logic             ack_i = 1'b0;
  logic             irq_o, overrun_o, rd_bank_o;
  logic [CNT_W-1:0] rd_evt_o, rd_ref_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  int  half_ns = 0;
  longint cyc = 0;
  longint last_cyc = 0;
  bit  last_valid = 0;
  logic exp_bank = 1'b1;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  freq_pingpong_meter #(.CNT_W(CNT_W), .WINDOW(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .meas_in(meas_in), .ack_i(ack_i),
    .irq_o(irq_o), .overrun_o(overrun_o), .rd_evt_o(rd_evt_o),
    .rd_ref_o(rd_ref_o), .rd_bank_o(rd_bank_o)
  );

  // Asynchronous input generator, offset from the clock grid.
  initial begin
    #1.3;
    forever begin
      if (half_ns == 0) begin
        meas_in = 1'b0;
        #1;
      end else begin
        #(half_ns);
        meas_in = ~meas_in;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_result();
    int n = 0;
    while (!irq_o && n < 4*W) begin
      @(negedge clk);
      n++;
    end
    check(irq_o == 1'b1, "R5 result flag within timeout", irq_o, 1);
    if (last_valid) check(cyc - last_cyc == W, "R8 result interval", cyc - last_cyc, W);
    last_cyc   = cyc;
    last_valid = 1;
    check(rd_ref_o == W, "R2 reference count", rd_ref_o, W);
    check(rd_bank_o == exp_bank, "R4 bank number", rd_bank_o, exp_bank);
    exp_bank = ~exp_bank;
  endtask

  task automatic do_ack();
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    check(irq_o == 1'b0, "R5 flag cleared by ack", irq_o, 0);
  endtask

  initial begin
    logic [CNT_W-1:0] s_evt, s_ref;
    logic             s_bank;
    repeat (5) @(negedge clk);
    check(irq_o == 0 && overrun_o == 0, "R1 flags in reset", {irq_o, overrun_o}, 0);
    check(rd_evt_o == 0 && rd_ref_o == 0 && rd_bank_o == 0, "R1 read port in reset",
          rd_evt_o + rd_ref_o + rd_bank_o, 0);
    rst = 1'b0;
    repeat (W/2) @(negedge clk);
    check(irq_o == 0 && rd_ref_o == 0 && rd_bank_o == 0, "R1 idle before first result",
          irq_o + rd_ref_o + rd_bank_o, 0);

    // Constant low input: zero events.
    wait_result();
    check(rd_evt_o == 0, "R9 idle input count", rd_evt_o, 0);
    do_ack();

    // Sweep of input periods.
    for (int i = 0; i < 8; i++) begin
      int h;
      int lo;
      case (i)
        0: h = 6;  1: h = 7;  2: h = 9;  3: h = 11;
        4: h = 15; 5: h = 22; 6: h = 37; default: h = 60;
      endcase
      half_ns = h;
      lo = (W*CLK_NS) / (2*h);
      wait_result(); do_ack();
      wait_result(); do_ack();
      wait_result();
      check(rd_evt_o >= lo && rd_evt_o <= lo + 1, "R3 event count", rd_evt_o, lo);
      s_evt = rd_evt_o; s_ref = rd_ref_o; s_bank = rd_bank_o;
      repeat (7) @(negedge clk);
      check(rd_evt_o == s_evt && rd_ref_o == s_ref && rd_bank_o == s_bank,
            "R7 held pair stable", rd_evt_o, s_evt);
      check(overrun_o == 0, "R6 no overrun when acked", overrun_o, 0);
      do_ack();
    end

    // Overrun: leave one result unacknowledged across the next.
    wait_result();
    repeat (W - 1) @(negedge clk);
    check(overrun_o == 0, "R6 no overrun before second result", overrun_o, 0);
    @(negedge clk);
    last_cyc = cyc;
    check(overrun_o == 1, "R6 overrun set", overrun_o, 1);
    check(irq_o == 1, "R5 flag held without ack", irq_o, 1);
    check(rd_bank_o == exp_bank, "R4 bank after overrun", rd_bank_o, exp_bank);
    exp_bank = ~exp_bank;
    do_ack();
    check(overrun_o == 0, "R6 overrun cleared by ack", overrun_o, 0);
    wait_result();
    check(overrun_o == 0, "R6 overrun stays clear", overrun_o, 0);
    do_ack();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule